// File: doc/BRIEF.md
# SMM Memory Window Remapper

This block decides whether a host memory access lands in the System Management Mode (SMM) memory window and, if it does, gives the DRAM address that serves it. Each cycle it takes a host address, a flag that says the processor is in SMM, and an access strobe. One cycle later it gives a hit flag and the translated DRAM address. The address decode in the memory controller uses these to send SMM accesses to DRAM that would otherwise go to the legacy video or BIOS regions.

One 8-bit control byte sets the behaviour. A host-side byte register port writes it and reads it back. A two-bit layout field picks one of four fixed relocations. Three of them use a 32 KB host window at E0000h that goes to DRAM at E0000h, A0000h or B0000h. The fourth uses a 64 KB host window at A0000h that goes to the same DRAM addresses. The window is always reachable while the processor is in SMM. A separate control bit also opens it to accesses made outside SMM.

Top module: `smm_window_remap`

## Requirements
- R1: Reset clears the control byte to 0x00, so reads at the control offset return 0 and the hit output is low.
- R2: A write with the register offset equal to 0x68 stores the whole byte, and it reads back at that offset. A write to any other offset leaves the control byte unchanged. A read at any other offset returns 0.
- R3: With layout field (control bits 7:6) equal to 0, a granted access in host E0000h–E7FFFh hits and translates to the same address.
- R4: With layout 1, a granted access in host E0000h–E7FFFh hits and translates to A0000h plus the offset within the window.
- R5: With layout 2, a granted access in host E0000h–E7FFFh hits and translates to B0000h plus the offset within the window.
- R6: With layout 3, a granted access in host A0000h–AFFFFh hits and translates to the same address.
- R7: An access outside the current layout's host window never hits.
- R8: An access is granted when smmActive is high, or when control bit 4 is 1. With smmActive low and bit 4 equal to 0, it never hits.
- R9: A cycle with accStrobe low produces no hit.
- R10: hit and dramAddr reflect the access strobed on the previous clock. A control write takes effect for accesses strobed on later cycles. An access in the same cycle as the write uses the old value.
- R11: Every access is decoded with the window base, size and DRAM base of a single layout, never a mix of two.
- R12: Whenever hit is low, dramAddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register offset for write and read |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational on regAddr) |
| hostAddr | input | ADDR_W | Host byte address of the access |
| smmActive | input | 1 | Processor is in SMM |
| accStrobe | input | 1 | Access valid this cycle |
| hit | output | 1 | Previous-cycle access falls in the open window |
| dramAddr | output | ADDR_W | Translated DRAM address, 0 when no hit |

## Verification
A wrong stored control byte shows on the next strobed access, one cycle after the strobe. Depending on which bits are wrong, the access hits in the wrong host range, returns the wrong DRAM base, or is granted or refused the wrong way outside SMM. Read-back at the control offset exposes the same fault in the cycle of the read. A datapath that mixes layouts would give a hit whose DRAM base does not belong to the window it matched. Accesses near the window edges (E7FFFh/E8000h, AFFFFh/B0000h) show that on the first such access. A write in the same cycle as an access checks that the new value is not used one cycle early.

// File: rtl/smm_remap_pkg.sv
package smm_remap_pkg;

  localparam int NUM_MODES = 4;

  typedef enum logic [1:0] {
    MAP_E_TO_E = 2'd0,
    MAP_E_TO_A = 2'd1,
    MAP_E_TO_B = 2'd2,
    MAP_A_TO_A = 2'd3
  } winMode_e;

  // Strobes from the control register to the datapath
  typedef struct packed {
    winMode_e mode;
    logic     openOutside;
  } winCtrl_t;

  function automatic logic [19:0] hostBaseOf(int m);
    return (m == 3) ? 20'hA0000 : 20'hE0000;
  endfunction

  function automatic logic [19:0] dramBaseOf(int m);
    case (m)
      0:       return 20'hE0000;
      1:       return 20'hA0000;
      2:       return 20'hB0000;
      default: return 20'hA0000;
    endcase
  endfunction

  function automatic int winSizeLog2(int m);
    return (m == 3) ? 16 : 15;
  endfunction

endpackage

// File: rtl/smm_ctrl_reg.sv
module smm_ctrl_reg
  import smm_remap_pkg::*;
#(
  parameter int              REG_AW      = 8,
  parameter logic [REG_AW-1:0] CTRL_OFFSET = REG_AW'(8'h68)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output winCtrl_t          winCtrl
);

  localparam int MODE_HI  = 7;
  localparam int MODE_LO  = 6;
  localparam int OPEN_BIT = 4;

  logic [7:0] ctrlQ;
  logic       selCtrl;

  assign selCtrl = (regAddr == CTRL_OFFSET);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (regWrEn && selCtrl) begin
      ctrlQ <= regWrData;
    end
  end

  assign regRdData           = selCtrl ? ctrlQ : 8'h00;
  assign winCtrl.mode        = winMode_e'(ctrlQ[MODE_HI:MODE_LO]);
  assign winCtrl.openOutside = ctrlQ[OPEN_BIT];

endmodule

// File: rtl/smm_window_dp.sv
module smm_window_dp
  import smm_remap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  winCtrl_t          winCtrl,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              smmActive,
  input  logic              accStrobe,
  output logic              hit,
  output logic [ADDR_W-1:0] dramAddr
);

  logic [NUM_MODES-1:0] modeMatch;
  logic [ADDR_W-1:0]    modeXlat [NUM_MODES];

  // One decoder per layout; the selected one supplies both match and address
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int                SZL = winSizeLog2(m);
    localparam logic [ADDR_W-1:0] HB  = ADDR_W'(hostBaseOf(m));
    localparam logic [ADDR_W-1:0] DB  = ADDR_W'(dramBaseOf(m));
    assign modeMatch[m] = (hostAddr[ADDR_W-1:SZL] == HB[ADDR_W-1:SZL]);
    assign modeXlat[m]  = {DB[ADDR_W-1:SZL], hostAddr[SZL-1:0]};
  end

  logic [1:0]        modeIdx;
  logic              granted;
  logic              hitNext;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    modeIdx  = winCtrl.mode;
    granted  = smmActive | winCtrl.openOutside;
    hitNext  = accStrobe & granted & modeMatch[modeIdx];
    addrNext = hitNext ? modeXlat[modeIdx] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit      <= 1'b0;
      dramAddr <= '0;
    end else begin
      hit      <= hitNext;
      dramAddr <= addrNext;
    end
  end

endmodule

// File: rtl/smm_window_remap.sv
module smm_window_remap
  import smm_remap_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                REG_AW      = 8,
  parameter logic [REG_AW-1:0] CTRL_OFFSET = REG_AW'(8'h68)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              smmActive,
  input  logic              accStrobe,
  output logic              hit,
  output logic [ADDR_W-1:0] dramAddr
);

  winCtrl_t winCtrl;

  smm_ctrl_reg #(
    .REG_AW     (REG_AW),
    .CTRL_OFFSET(CTRL_OFFSET)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .winCtrl  (winCtrl)
  );

  smm_window_dp #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .winCtrl  (winCtrl),
    .hostAddr (hostAddr),
    .smmActive(smmActive),
    .accStrobe(accStrobe),
    .hit      (hit),
    .dramAddr (dramAddr)
  );

endmodule

// File: rtl/smm_remap_checker.sv
module smm_remap_checker
  import smm_remap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input winCtrl_t          winCtrl,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              smmActive,
  input logic              accStrobe,
  input logic              hit,
  input logic [ADDR_W-1:0] dramAddr
);

  // R1: while reset is held, no hit follows
  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> !hit);

  // R9: no strobe, no hit on the next cycle
  p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    !accStrobe |=> !hit);

  // R8: closed window outside SMM refuses access
  p_closed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && !smmActive && !winCtrl.openOutside) |=> !hit);

  // R12: translated address is zero without a hit
  p_addr_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (dramAddr == '0));

  // R7: every hit lands in one of the legal DRAM regions
  p_region_r7: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> ((dramAddr >= ADDR_W'(20'hA0000) && dramAddr < ADDR_W'(20'hB8000)) ||
             (dramAddr >= ADDR_W'(20'hE0000) && dramAddr < ADDR_W'(20'hE8000))));

  // R6: 64 KB identity window in layout 3
  p_mode3_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && smmActive && winCtrl.mode == MAP_A_TO_A &&
     hostAddr >= ADDR_W'(20'hA0000) && hostAddr < ADDR_W'(20'hB0000))
    |=> (hit && dramAddr == $past(hostAddr)));

  // R11: the offset within the window always survives translation
  p_offset_r11: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (dramAddr[14:0] == $past(hostAddr[14:0])));

endmodule

bind smm_window_remap smm_remap_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .winCtrl  (winCtrl),
  .hostAddr (hostAddr),
  .smmActive(smmActive),
  .accStrobe(accStrobe),
  .hit      (hit),
  .dramAddr (dramAddr)
);

// File: tb/sim_smm_window_remap.sv
module sim_smm_window_remap;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [7:0]    regAddr = 8'h00;
  logic [7:0]    regWrData = 8'h00;
  logic [7:0]    regRdData;
  logic [AW-1:0] hostAddr = '0;
  logic          smmActive = 1'b0;
  logic          accStrobe = 1'b0;
  logic          hit;
  logic [AW-1:0] dramAddr;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] modelCtrl = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  smm_window_remap u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hostAddr(hostAddr),
    .smmActive(smmActive), .accStrobe(accStrobe), .hit(hit), .dramAddr(dramAddr)
  );

  // Expected {hit, addr} from the requirements
  function automatic logic [AW:0] model(logic [7:0] c, logic smm, logic strb, logic [AW-1:0] a);
    logic [AW-1:0] hb, db, sz;
    logic h;
    case (c[7:6])
      2'd0: begin hb = 32'hE0000; db = 32'hE0000; sz = 32'h8000; end
      2'd1: begin hb = 32'hE0000; db = 32'hA0000; sz = 32'h8000; end
      2'd2: begin hb = 32'hE0000; db = 32'hB0000; sz = 32'h8000; end
      default: begin hb = 32'hA0000; db = 32'hA0000; sz = 32'h10000; end
    endcase
    h = strb && (a >= hb) && (a < hb + sz) && (smm || c[4]);
    return {h, h ? db + (a - hb) : '0};
  endfunction

  task automatic check(bit ok, string req, logic [AW:0] act, logic [AW:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, clock, sample at the following negedge
  task automatic step(logic [AW-1:0] a, logic smm, logic strb,
                      logic wr, logic [7:0] wa, logic [7:0] wd, string req);
    logic [AW:0] exp;
    hostAddr = a; smmActive = smm; accStrobe = strb;
    regWrEn = wr; regAddr = wa; regWrData = wd;
    exp = model(modelCtrl, smm, strb, a);
    @(posedge clk);
    if (wr && wa == 8'h68) modelCtrl = wd;
    @(negedge clk);
    check({hit, dramAddr} === exp, req, {hit, dramAddr}, exp);
    regWrEn = 1'b0; accStrobe = 1'b0;
  endtask

  task automatic wrReg(logic [7:0] wa, logic [7:0] wd, string req);
    step('0, 1'b0, 1'b0, 1'b1, wa, wd, req);
  endtask

  task automatic rdCheck(logic [7:0] ra, logic [7:0] exp, string req);
    regAddr = ra;
    #1;
    check(regRdData === exp, req, {25'd0, regRdData}, {25'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(hit === 1'b0, "R1", {32'd0, hit}, '0);
    rdCheck(8'h68, 8'h00, "R1");
    rstN = 1'b1;
    @(negedge clk);

    // R3: layout 0 identity, in SMM
    step(32'hE0100, 1, 1, 0, 8'h00, 8'h00, "R3");
    step(32'hE7FFF, 1, 1, 0, 8'h00, 8'h00, "R3");
    // R8: closed outside SMM
    step(32'hE0100, 0, 1, 0, 8'h00, 8'h00, "R8");
    wrReg(8'h68, 8'h10, "R2");
    rdCheck(8'h68, 8'h10, "R2");
    step(32'hE0100, 0, 1, 0, 8'h00, 8'h00, "R8");
    // R2: write to another offset ignored
    wrReg(8'h69, 8'hC0, "R2");
    rdCheck(8'h68, 8'h10, "R2");
    rdCheck(8'h69, 8'h00, "R2");
    step(32'hA0000, 1, 1, 0, 8'h00, 8'h00, "R2");
    // R4: layout 1
    wrReg(8'h68, 8'h40, "R4");
    step(32'hE7FFF, 1, 1, 0, 8'h00, 8'h00, "R4");
    step(32'hE0000, 1, 1, 0, 8'h00, 8'h00, "R4");
    step(32'hE8000, 1, 1, 0, 8'h00, 8'h00, "R7");
    step(32'hDFFFF, 1, 1, 0, 8'h00, 8'h00, "R7");
    // R5: layout 2
    wrReg(8'h68, 8'h80, "R5");
    step(32'hE1234, 1, 1, 0, 8'h00, 8'h00, "R5");
    // R10: same-cycle write uses old layout, next access the new one
    step(32'hA0000, 1, 1, 1, 8'h68, 8'hC0, "R10");
    step(32'hA0000, 1, 1, 0, 8'h00, 8'h00, "R6");
    step(32'hAFFFF, 1, 1, 0, 8'h00, 8'h00, "R6");
    step(32'hB0000, 1, 1, 0, 8'h00, 8'h00, "R7");
    step(32'hE0000, 1, 1, 0, 8'h00, 8'h00, "R11");
    // R9/R12: no strobe
    step(32'hA1000, 1, 0, 0, 8'h00, 8'h00, "R9");
    check(dramAddr === '0, "R12", {1'b0, dramAddr}, '0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [7:0] wa;
      case ($urandom % 6)
        0: a = 32'hA0000; 1: a = 32'hB0000; 2: a = 32'hE0000;
        3: a = 32'hE8000; 4: a = 32'hD8000; default: a = 32'h0;
      endcase
      a = a + ($urandom % 32'h10000) - ($urandom % 4);
      if ($urandom % 16 == 0) a = $urandom;
      wa = ($urandom % 2 == 0) ? 8'h68 : 8'($urandom);
      step(a, 1'($urandom), ($urandom % 4) != 0, ($urandom % 8) == 0,
           wa, 8'($urandom), "R11");
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule